// File: doc/BRIEF.md
# Second-Order Noise Shaper with Bidirectional Thermometer Encoder

This block takes one audio channel of 18-bit two's complement samples at the 96x oversampled rate. A second-order error-feedback loop reduces each sample to a 5-bit two's complement level. That level is then spread over 32 unit-element enables: 16 lines steer current sources for positive levels and 16 lines steer current sinks for negative levels. Because of this split, a quiet passage drives only one or two elements, and every single-step change of the level switches exactly one element.

The loop and the output registers advance only on cycles where the rate strobe `tick` is high. With silence at the input, the quantizer settles into a two-level pattern (0 and -1) around zero, which amounts to a 1-bit bitstream. Large inputs are clamped to the 5-bit range. The stored error terms are saturated so that the loop comes back to normal operation once an overload ends. The analog cells, their calibration and the output stage are outside this block.

Top module: `nshape_therm`

## Requirements
- R1: While reset is active, and after it, until the first tick, the level output is 0 and all 32 element lines are off. Both stored error terms start at zero, so the first ticks after reset with zero input produce the pattern of R5.
- R2: On each tick the loop forms v = x + 2*e1 - e2, where x is the sign-extended input sample, e1 is the previous error and e2 is the error before that. The level is floor(v / 8192), clamped to the range -16..+15.
- R3: The new error is e = v - (level*8192 + 4096). It is stored saturated to the range -8192..+8192. On each tick the old e1 moves into e2.
- R4: A full-scale positive input held steady gives level +15. A full-scale negative input held steady gives level -16.
- R5: With zero input from the reset state, the level sequence is 0, -1, -1, 0, repeating, so only the two levels 0 and -1 occur.
- R6: A level L >= 0 turns on source lines 0..L-1 (bit i of `src_en`) with all sink lines off. A level L < 0 turns on sink lines 0..|L|-1 (bit i of `snk_en`) with all source lines off. Source line 15 is never on, because the highest level is +15.
- R7: Source and sink lines are never on in the same cycle.
- R8: When the level changes by exactly one between two consecutive tick results, exactly one of the 32 lines changes state.
- R9: In a cycle where `tick` is low, the level, the lines and the loop state hold their values.
- R10: The outputs are registered. The result for the sample presented at a clock edge with `tick` high appears right after that edge.
- R11: After an overload at either full-scale limit, a zero input brings the level back into {-1, 0} within 8 ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick | input | 1 | Rate strobe; the loop advances on cycles where it is high |
| sample_in | input | 18 | Signed input sample |
| level_out | output | 5 | Signed quantized level, -16..+15 |
| src_en | output | 16 | Source element enables, filled from bit 0 upward |
| snk_en | output | 16 | Sink element enables, filled from bit 0 upward |

## Verification
The bench targets the idle limit cycle just after reset. A loop whose feedback is wired with the wrong sign or the wrong order, or whose reset leaves error state behind, breaks the exact 0, -1, -1, 0 pattern. It drives both full-scale limits and then returns to silence: a loop without error saturation stays stuck at the rail or rings long after the overload ends, and a wrong clamp shows up as levels outside the range. A slow ramp through every level checks that each step flips one line and that the source and sink banks never overlap; an encoder that fills from the wrong end or uses an offset count fails here. A run with `tick` held low and a changing input confirms that nothing moves between strobes.

// File: rtl/ns_pkg.sv
package ns_pkg;
  localparam int NS_DATA_W = 18;
  localparam int NS_LVL_W  = 5;

  typedef enum logic [1:0] {
    POL_IDLE = 2'd0,
    POL_SRC  = 2'd1,
    POL_SNK  = 2'd2
  } pol_e;
endpackage

// File: rtl/ns_quant.sv
module ns_quant #(
  parameter int ACC_W = 21,
  parameter int SHIFT = 13,
  parameter int LVL_W = 5,
  parameter int E_W   = 15
) (
  input  logic signed [ACC_W-1:0] v_in,
  output logic signed [LVL_W-1:0] lvl,
  output logic signed [E_W-1:0]   err
);
  localparam int QW   = ACC_W - SHIFT;
  localparam int QMAX = 2**(LVL_W-1) - 1;
  localparam int QMIN = -(2**(LVL_W-1));
  localparam int ELIM = 2**SHIFT;

  logic signed [QW-1:0]    q_raw;
  logic signed [ACC_W-1:0] rec;
  logic signed [ACC_W-1:0] e_full;

  always_comb begin
    q_raw = v_in[ACC_W-1:SHIFT];
    if (int'(q_raw) > QMAX) begin
      lvl = LVL_W'(QMAX);
    end else if (int'(q_raw) < QMIN) begin
      lvl = LVL_W'(QMIN);
    end else begin
      lvl = q_raw[LVL_W-1:0];
    end
    rec    = ({{(ACC_W-LVL_W){lvl[LVL_W-1]}}, lvl} <<< SHIFT) + ACC_W'(ELIM/2);
    e_full = v_in - rec;
    if (int'(e_full) > ELIM) begin
      err = E_W'(ELIM);
    end else if (int'(e_full) < -ELIM) begin
      err = E_W'(-ELIM);
    end else begin
      err = e_full[E_W-1:0];
    end
  end
endmodule

// File: rtl/ns_loop.sv
module ns_loop #(
  parameter int DATA_W = 18,
  parameter int LVL_W  = 5
) (
  input  logic                     clk,
  input  logic                     rst_i_n,
  input  logic                     tick,
  input  logic signed [DATA_W-1:0] sample,
  output logic signed [LVL_W-1:0]  lvl_c
);
  localparam int SHIFT = DATA_W - LVL_W;
  localparam int E_W   = SHIFT + 2;
  localparam int ACC_W = DATA_W + 3;
  localparam int ELIM  = 2**SHIFT;

  logic signed [E_W-1:0]   e1_q, e2_q, e1_d, e2_d, err_c;
  logic signed [ACC_W-1:0] x_ext, e1_ext, e2_ext, fb, v_sum;

  always_comb begin
    x_ext  = {{(ACC_W-DATA_W){sample[DATA_W-1]}}, sample};
    e1_ext = {{(ACC_W-E_W){e1_q[E_W-1]}}, e1_q};
    e2_ext = {{(ACC_W-E_W){e2_q[E_W-1]}}, e2_q};
    fb     = (e1_ext <<< 1) - e2_ext;
    v_sum  = x_ext + fb;
  end

  ns_quant #(
    .ACC_W(ACC_W),
    .SHIFT(SHIFT),
    .LVL_W(LVL_W),
    .E_W  (E_W)
  ) quant_i (
    .v_in(v_sum),
    .lvl (lvl_c),
    .err (err_c)
  );

  always_comb begin
    e1_d = e1_q;
    e2_d = e2_q;
    if (tick) begin
      e1_d = err_c;
      e2_d = e1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      e1_q <= '0;
      e2_q <= '0;
    end else begin
      e1_q <= e1_d;
      e2_q <= e2_d;
    end
  end

  // R3: stored error never leaves the saturation window
  assert_err_bound_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    (int'(e1_q) <= ELIM) && (int'(e1_q) >= -ELIM));

  // R3: error history shifts by one on each tick
  assert_err_shift_R3: assert property (@(posedge clk) disable iff (!rst_i_n)
    tick |=> (e2_q == $past(e1_q)));

  // R9: loop state frozen between ticks
  assert_state_hold_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    !tick |=> ($stable(e1_q) && $stable(e2_q)));
endmodule

// File: rtl/ns_therm_enc.sv
module ns_therm_enc
  import ns_pkg::*;
#(
  parameter int LVL_W = 5
) (
  input  logic signed [LVL_W-1:0]      lvl,
  output logic [2**(LVL_W-1)-1:0]      src,
  output logic [2**(LVL_W-1)-1:0]      snk
);
  localparam int NL = 2**(LVL_W-1);

  pol_e             pol;
  logic [LVL_W-1:0] mag;

  always_comb begin
    if (lvl[LVL_W-1]) begin
      pol = POL_SNK;
      mag = -lvl;
    end else if (lvl == '0) begin
      pol = POL_IDLE;
      mag = '0;
    end else begin
      pol = POL_SRC;
      mag = lvl;
    end
  end

  for (genvar i = 0; i < NL; i++) begin : g_line
    assign src[i] = (pol == POL_SRC) && (mag > LVL_W'(i));
    assign snk[i] = (pol == POL_SNK) && (mag > LVL_W'(i));
  end
endmodule

// File: rtl/nshape_therm.sv
module nshape_therm #(
  parameter int DATA_W = ns_pkg::NS_DATA_W,
  parameter int LVL_W  = ns_pkg::NS_LVL_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         tick,
  input  logic signed [DATA_W-1:0]     sample_in,
  output logic signed [LVL_W-1:0]      level_out,
  output logic [2**(LVL_W-1)-1:0]      src_en,
  output logic [2**(LVL_W-1)-1:0]      snk_en
);
  localparam int NL = 2**(LVL_W-1);

  logic [1:0]              rst_sync;
  logic                    rst_i_n;
  logic signed [LVL_W-1:0] lvl_c, level_q, level_d;
  logic [NL-1:0]           src_c, snk_c, src_q, snk_q, src_d, snk_d;
  logic                    past_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync <= 2'b00;
    end else begin
      rst_sync <= {rst_sync[0], 1'b1};
    end
  end
  assign rst_i_n = rst_sync[1];

  ns_loop #(
    .DATA_W(DATA_W),
    .LVL_W (LVL_W)
  ) loop_i (
    .clk    (clk),
    .rst_i_n(rst_i_n),
    .tick   (tick),
    .sample (sample_in),
    .lvl_c  (lvl_c)
  );

  ns_therm_enc #(
    .LVL_W(LVL_W)
  ) enc_i (
    .lvl(lvl_c),
    .src(src_c),
    .snk(snk_c)
  );

  always_comb begin
    level_d = level_q;
    src_d   = src_q;
    snk_d   = snk_q;
    if (tick) begin
      level_d = lvl_c;
      src_d   = src_c;
      snk_d   = snk_c;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      level_q <= '0;
      src_q   <= '0;
      snk_q   <= '0;
      past_ok <= 1'b0;
    end else begin
      level_q <= level_d;
      src_q   <= src_d;
      snk_q   <= snk_d;
      past_ok <= 1'b1;
    end
  end

  assign level_out = level_q;
  assign src_en    = src_q;
  assign snk_en    = snk_q;

  // R7: banks mutually exclusive
  assert_bank_excl_R7: assert property (@(posedge clk) disable iff (!rst_i_n)
    !((|src_q) && (|snk_q)));

  // R6: the top source line is unreachable
  assert_src_top_off_R6: assert property (@(posedge clk) disable iff (!rst_i_n)
    !src_q[NL-1]);

  // R6: active line count equals level magnitude
  assert_line_count_R6: assert property (@(posedge clk) disable iff (!rst_i_n)
    $countones({src_q, snk_q}) == ((int'(level_q) < 0) ? -int'(level_q) : int'(level_q)));

  // R8: unit level step flips one element
  assert_one_flip_R8: assert property (@(posedge clk) disable iff (!rst_i_n)
    (past_ok && (((int'(level_q) - int'($past(level_q))) == 1) ||
                 ((int'(level_q) - int'($past(level_q))) == -1)))
    |-> ($countones({src_q, snk_q} ^ $past({src_q, snk_q})) == 1));

  // R9: outputs frozen between ticks
  assert_out_hold_R9: assert property (@(posedge clk) disable iff (!rst_i_n)
    !tick |=> ($stable(level_q) && $stable(src_q) && $stable(snk_q)));
endmodule

// File: tb/nshape_therm_tb.sv
module nshape_therm_tb_top;
  localparam int DATA_W = 18;
  localparam int LVL_W  = 5;
  localparam int NL     = 16;
  localparam int STEP   = 8192;
  localparam int HALF   = 4096;
  localparam int NTBL   = 9;

  // {input sample, lowest and highest level allowed once settled}
  localparam int TBL [NTBL][3] = '{
    '{ 3*8192,      1,   4},
    '{-5*8192,     -7,  -4},
    '{ 0,          -1,   0},
    '{ 131071,     15,  15},
    '{ 0,          -1,   0},
    '{-131072,    -16, -16},
    '{ 0,          -1,   0},
    '{ 7*8192+100,  4,   9},
    '{-10*8192,   -12,  -9}
  };

  logic                     clk;
  logic                     rst_n;
  logic                     tick;
  logic signed [DATA_W-1:0] sample_in;
  logic signed [LVL_W-1:0]  level_out;
  logic [NL-1:0]            src_en, snk_en;

  int checks = 0;
  int errors = 0;
  int m_e1, m_e2, m_lvl;
  bit done = 0;

  nshape_therm #(.DATA_W(DATA_W), .LVL_W(LVL_W)) dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .sample_in(sample_in),
    .level_out(level_out),
    .src_en   (src_en),
    .snk_en   (snk_en)
  );

  initial begin
    clk = 1'b0;
    forever #4 clk = ~clk;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_src(input int l);
    int r = 0;
    for (int i = 0; i < NL; i++) if (l > i) r |= (1 << i);
    return r;
  endfunction

  function automatic int exp_snk(input int l);
    int r = 0;
    for (int i = 0; i < NL; i++) if (-l > i) r |= (1 << i);
    return r;
  endfunction

  task automatic model_step(input int x);
    int v, q, e;
    v = x + 2*m_e1 - m_e2;
    q = v >>> 13;
    if (q > 15) q = 15;
    if (q < -16) q = -16;
    e = v - (q*STEP + HALF);
    if (e > STEP) e = STEP;
    if (e < -STEP) e = -STEP;
    m_e2 = m_e1;
    m_e1 = e;
    m_lvl = q;
  endtask

  task automatic step(input int x, input bit tk);
    int prev_lvl, prev_lines, now_lines, diff;
    prev_lvl   = int'(level_out);
    prev_lines = int'({src_en, snk_en});
    sample_in  = DATA_W'(x);
    tick       = tk;
    @(posedge clk);
    @(negedge clk);
    if (tk) model_step(x);
    chk("R2/R10 level", int'(level_out), m_lvl);
    chk("R6 src_en", int'(src_en), exp_src(m_lvl));
    chk("R6 snk_en", int'(snk_en), exp_snk(m_lvl));
    chk("R7 overlap", int'((|src_en) && (|snk_en)), 0);
    if (!tk) chk("R9 hold", int'(level_out), prev_lvl);
    diff = int'(level_out) - prev_lvl;
    if (diff == 1 || diff == -1) begin
      now_lines = int'({src_en, snk_en});
      chk("R8 one flip", $countones(now_lines ^ prev_lines), 1);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick  = 1'b0;
    sample_in = '0;
    m_e1 = 0; m_e2 = 0; m_lvl = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R1 reset level", int'(level_out), 0);
    chk("R1 reset lines", int'({src_en, snk_en}), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 level after release", int'(level_out), 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int idle_pat [8] = '{0, -1, -1, 0, 0, -1, -1, 0};
    rst_n = 1'b0;
    tick = 1'b0;
    sample_in = '0;
    @(negedge clk);
    do_reset();

    // R5 / R1: idle pattern straight out of reset
    for (int n = 0; n < 8; n++) begin
      step(0, 1'b1);
      chk("R5 idle pattern", int'(level_out), idle_pat[n]);
    end

    // table of DC inputs; R4 limits, R11 recovery
    for (int k = 0; k < NTBL; k++) begin
      for (int n = 0; n < 16; n++) begin
        step(TBL[k][0], 1'b1);
        if (n >= 8) begin
          chk("R4/R11 settled low bound", int'(int'(level_out) >= TBL[k][1]), 1);
          chk("R4/R11 settled high bound", int'(int'(level_out) <= TBL[k][2]), 1);
        end
      end
    end

    // R9: strobe low with changing input
    step(5*8192, 1'b1);
    step(5*8192, 1'b1);
    for (int n = 0; n < 4; n++) step(-100000 + n*50000, 1'b0);
    for (int n = 0; n < 6; n++) step(5*8192, 1'b1);

    // R8 / R6: slow ramp across the full range
    for (int x = -131072; x <= 131071; x += 2048) step(x, 1'b1);
    for (int x = 131071; x >= -131072; x -= 3000) step(x, 1'b1);

    // R1: mid-run reset clears the error history
    step(9*8192, 1'b1);
    do_reset();
    for (int n = 0; n < 4; n++) begin
      step(0, 1'b1);
      chk("R1 state cleared", int'(level_out), idle_pat[n]);
    end

    finish_run();
  end
endmodule